// File: doc/BRIEF.md
# Audio Serial Transmitter with Clock Master

This block turns a stereo pair of parallel samples into a one-wire serial audio stream, most significant bit first in two's complement. It can time the stream itself, dividing its master clock down to a 64fs bit clock and an fs frame clock. It can also follow a bit clock and frame clock that another device drives. All logic runs on the master clock `clk`. In follower mode the external clocks are resynchronized and their edges detected, so data moves a few `clk` cycles after each external falling bit-clock edge.

Two configuration inputs are captured only while `pdn` is high. A 3-bit clock mode picks the divider ratio, follower operation, or a quiet reserved state. A 2-bit format picks 16-bit right-aligned, 20-bit right-aligned, left-aligned, or I2S framing. Samples are written into a holding pair at any time with a strobe. The pair is copied into the shift words at the start of each left half-frame, so a word never changes while it is being sent.

Top module: `aud_ser_tx`

## Requirements
- R1: `cmode_i` and `ofmt_i` are captured only on clock edges where `pdn` is 1; changes while `pdn` is 0 have no effect. Any edge with `pdn` = 1 forces `bclk_o`, `lrck_o` and `sdata_o` to 0.
- R2: In clock modes 000, 001, 010, 011 and 111, `bclk_o` has a period of 4, 6, 8, 12 and 4 `clk` cycles. Each period is low for the first half and high for the second.
- R3: In the modes of R2, `lrck_o` changes level only on the edge where `bclk_o` falls. It holds each level for 32 bit-clock periods.
- R4: In the modes of R2, `sdata_o` changes only on a `clk` edge where `bclk_o` falls.
- R5: Format 00 sends bits [19:4] of the sample in the last 16 slots of each 32-slot half-frame, so the LSB is in the last slot. The leading slots carry 0.
- R6: Format 01 sends all 20 bits right-aligned in the same way, with the LSB in the last slot.
- R7: Format 10 sends the MSB in the first slot after the frame-clock change, followed by the rest of the word. The remaining slots carry 0.
- R8: Format 11 (I2S) delays the MSB by one slot, and the left channel is sent while the frame clock is low. In the other formats the left channel is sent while it is high. At a 32fs bit clock, the LSB of the 16-bit word goes out in slot 0 of the following half-frame.
- R9: In formats 10 and 11 the word is 16 bits (sample bits [19:4]) when the previous half-frame had exactly 16 bit clocks. Otherwise it is 20 bits.
- R10: In clock mode 100, `bclk_o` and `lrck_o` stay 0. Framing follows `bclk_i` and `lrck_i`, and `sdata_o` is valid before the next rising edge of `bclk_i`.
- R11: In clock modes 101 and 110, all three outputs stay 0.
- R12: A pulse on `smp_wr_i` loads `smp_l_i` and `smp_r_i` into a holding pair. The pair is copied into the transmit words only at the start of a left half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdn | input | 1 | Power-down; configuration capture window |
| cmode_i | input | 3 | Clock-mode select |
| ofmt_i | input | 2 | Output format select |
| smp_wr_i | input | 1 | Write strobe for the holding pair |
| smp_l_i | input | 20 | Left sample, two's complement |
| smp_r_i | input | 20 | Right sample, two's complement |
| bclk_i | input | 1 | External bit clock (follower mode) |
| lrck_i | input | 1 | External frame clock (follower mode) |
| bclk_o | output | 1 | Generated bit clock |
| lrck_o | output | 1 | Generated frame clock |
| sdata_o | output | 1 | Serial data |

## Verification
Some properties are checked on every cycle. Configuration holds outside power-down. The high phase of the generated bit clock lasts half the divider ratio. Frame-clock and data changes line up with a falling bit clock. Right-aligned padding and short-word tails are zero. Generated clocks stay quiet in follower and reserved modes. The exact bit sent in each slot cannot be checked that way. Nor can taking samples only at a frame start, or picking the word length from the measured bit-clock rate. The bench shows those with a per-cycle reference model in master modes, and with checks at each external rising edge for 32fs, 48fs and 64fs external clocks.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int unsigned SMP_W   = 20;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned IDX_W   = $clog2(SMP_W);
  localparam int unsigned CNT_W   = 7;
  localparam int unsigned DIV_W   = 4;

  typedef enum logic [2:0] {
    CM_256    = 3'b000,
    CM_384    = 3'b001,
    CM_512    = 3'b010,
    CM_768    = 3'b011,
    CM_FOLLOW = 3'b100,
    CM_RSV_A  = 3'b101,
    CM_RSV_B  = 3'b110,
    CM_BYPASS = 3'b111
  } clk_mode_e;

  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ20 = 2'b01,
    FMT_LJ   = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;

  // master clock cycles per bit clock
  function automatic logic [DIV_W-1:0] mclk_div(clk_mode_e m);
    case (m)
      CM_384:  return DIV_W'(6);
      CM_512:  return DIV_W'(8);
      CM_768:  return DIV_W'(12);
      default: return DIV_W'(4);
    endcase
  endfunction

  function automatic logic left_level(fmt_e f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

  function automatic int word_len(fmt_e f, logic [CNT_W-1:0] hlen);
    case (f)
      FMT_RJ16: return SHORT_W;
      FMT_RJ20: return SMP_W;
      default:  return (int'(hlen) == SHORT_W) ? SHORT_W : SMP_W;
    endcase
  endfunction

  // bit driven in slot b of a half-frame holding hl slots
  function automatic logic slot_bit(fmt_e f, logic [SMP_W-1:0] w,
                                    logic [SMP_W-1:0] wp,
                                    logic [CNT_W-1:0] b,
                                    logic [CNT_W-1:0] hl);
    int wl;
    int k;
    logic [IDX_W-1:0] idx;
    logic r;
    wl  = word_len(f, hl);
    r   = 1'b0;
    idx = '0;
    case (f)
      FMT_RJ16, FMT_RJ20: k = int'(b) - (int'(hl) - wl);
      FMT_LJ:             k = int'(b);
      default:            k = int'(b) - 1;
    endcase
    if (k >= 0 && k < wl) begin
      idx = IDX_W'(SMP_W - 1 - k);
      r   = w[idx];
    end else if (f == FMT_I2S && b == '0 && int'(hl) == wl) begin
      idx = IDX_W'(SMP_W - wl);
      r   = wp[idx];
    end
    return r;
  endfunction
endpackage

// File: rtl/aud_tx_cfg.sv
module aud_tx_cfg
  import aud_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdn,
  input  logic [2:0]       mode_pins,
  input  logic [1:0]       fmt_pins,
  output fmt_e             fmt_q,
  output logic             is_master,
  output logic             is_slave,
  output logic [DIV_W-1:0] div_n,
  output logic             left_lvl
);
  clk_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CM_FOLLOW;
      fmt_q  <= FMT_LJ;
    end else if (pdn) begin
      mode_q <= clk_mode_e'(mode_pins);
      fmt_q  <= fmt_e'(fmt_pins);
    end
  end

  always_comb begin
    is_master = (mode_q == CM_256) || (mode_q == CM_384) || (mode_q == CM_512) ||
                (mode_q == CM_768) || (mode_q == CM_BYPASS);
    is_slave  = (mode_q == CM_FOLLOW);
    div_n     = mclk_div(mode_q);
    left_lvl  = left_level(fmt_q);
  end

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn |=> ($stable(mode_q) && $stable(fmt_q)));
endmodule

// File: rtl/aud_tx_mclkgen.sv
module aud_tx_mclkgen
  import aud_tx_pkg::*;
#(
  parameter int unsigned SLOT_W = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_n,
  input  logic             left_lvl,
  output logic             tick,
  output logic             lrck_nxt,
  output logic             bclk_o,
  output logic             lrck_o
);
  localparam int unsigned HALF = 2 ** (SLOT_W - 1);

  logic [DIV_W-1:0]  div_cnt, div_nxt;
  logic [SLOT_W-1:0] slot, slot_nxt;
  logic [DIV_W-1:0]  hi_len;

  always_comb begin
    tick     = run && (div_cnt == div_n - DIV_W'(1));
    div_nxt  = tick ? '0 : div_cnt + DIV_W'(1);
    slot_nxt = slot + SLOT_W'(1);
    lrck_nxt = (int'(slot_nxt) < HALF) ? left_lvl : ~left_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      slot    <= '1;
      bclk_o  <= 1'b0;
      lrck_o  <= 1'b0;
    end else if (!run) begin
      div_cnt <= '0;
      slot    <= '1;
      bclk_o  <= 1'b0;
      lrck_o  <= 1'b0;
    end else begin
      div_cnt <= div_nxt;
      bclk_o  <= (div_nxt >= (div_n >> 1));
      if (tick) begin
        slot   <= slot_nxt;
        lrck_o <= lrck_nxt;
      end
    end
  end

  // checker-side high-phase length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= '0;
    else if (!run)    hi_len <= '0;
    else if (bclk_o)  hi_len <= hi_len + DIV_W'(1);
    else              hi_len <= '0;
  end

  assert_bclk_duty_R2: assert property (@(posedge clk) disable iff (!rst_n || !run)
    $fell(bclk_o) |-> (hi_len == (div_n >> 1)));
endmodule

// File: rtl/aud_tx_slvsync.sv
module aud_tx_slvsync #(
  parameter int unsigned SYNC_N = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bclk_in,
  input  logic lrck_in,
  output logic tick,
  output logic lrck_lvl
);
  logic [SYNC_N:0]   bsync;
  logic [SYNC_N-1:0] lsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync <= '0;
      lsync <= '0;
    end else begin
      bsync <= {bsync[SYNC_N-1:0], bclk_in};
      lsync <= {lsync[SYNC_N-2:0], lrck_in};
    end
  end

  // falling edge of the resynchronized bit clock; frame clock at equal depth
  assign tick     = run && bsync[SYNC_N] && !bsync[SYNC_N-1];
  assign lrck_lvl = lsync[SYNC_N-1];
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
  import aud_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdn,
  input  logic             tick,
  input  logic             lrck_lvl,
  input  fmt_e             fmt,
  input  logic             left_lvl,
  input  logic             smp_wr,
  input  logic [SMP_W-1:0] smp_l,
  input  logic [SMP_W-1:0] smp_r,
  output logic             sdata_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] HLEN_DEF = CNT_W'(32);

  logic [SMP_W-1:0] hold_l, hold_r, cur_l, cur_r;
  logic [CNT_W-1:0] b_cnt, b_nxt, hlen, hlen_nxt;
  logic             lrck_last, seen_edge, synced, synced_nxt;
  logic             lr_edge, frame_start, is_left, bit_nxt;
  logic [SMP_W-1:0] word, word_prev;

  always_comb begin
    lr_edge     = tick && (lrck_lvl != lrck_last);
    is_left     = (lrck_lvl == left_lvl);
    frame_start = lr_edge && is_left;
    b_nxt       = lr_edge ? '0 : ((b_cnt == CNT_MAX) ? CNT_MAX : b_cnt + CNT_W'(1));
    hlen_nxt    = (lr_edge && seen_edge) ? b_cnt + CNT_W'(1) : hlen;
    synced_nxt  = synced || frame_start;
    word        = is_left ? (frame_start ? hold_l : cur_l) : cur_r;
    word_prev   = is_left ? cur_r : cur_l;
    bit_nxt     = synced_nxt ? slot_bit(fmt, word, word_prev, b_nxt, hlen_nxt) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (smp_wr) begin
      hold_l <= smp_l;
      hold_r <= smp_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_l <= '0; cur_r <= '0; b_cnt <= '0; hlen <= HLEN_DEF;
      lrck_last <= 1'b0; seen_edge <= 1'b0; synced <= 1'b0; sdata_o <= 1'b0;
    end else if (pdn) begin
      cur_l <= '0; cur_r <= '0; b_cnt <= '0; hlen <= HLEN_DEF;
      lrck_last <= ~left_lvl; seen_edge <= 1'b0; synced <= 1'b0; sdata_o <= 1'b0;
    end else if (tick) begin
      b_cnt     <= b_nxt;
      hlen      <= hlen_nxt;
      lrck_last <= lrck_lvl;
      seen_edge <= seen_edge || lr_edge;
      synced    <= synced_nxt;
      sdata_o   <= bit_nxt;
      if (frame_start) begin
        cur_l <= hold_l;
        cur_r <= hold_r;
      end
    end
  end

  assert_rj16_pad_R5: assert property (@(posedge clk) disable iff (!rst_n || pdn)
    (tick && fmt == FMT_RJ16 && hlen_nxt == HLEN_DEF && b_nxt < CNT_W'(16)) |=> !sdata_o);

  assert_short_tail_R9: assert property (@(posedge clk) disable iff (!rst_n || pdn)
    (tick && (fmt == FMT_LJ || fmt == FMT_I2S) && hlen_nxt == CNT_W'(SHORT_W) &&
     b_nxt > CNT_W'(SHORT_W)) |=> !sdata_o);
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned SLOT_W = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdn,
  input  logic [2:0]       cmode_i,
  input  logic [1:0]       ofmt_i,
  input  logic             smp_wr_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             bclk_i,
  input  logic             lrck_i,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             sdata_o
);
  fmt_e             fmt_q;
  logic             is_master, is_slave, left_lvl;
  logic [DIV_W-1:0] div_n;
  logic             master_run, slave_run;
  logic             m_tick, m_lrck, s_tick, s_lrck;
  logic             tick, lrck_lvl;

  aud_tx_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .mode_pins(cmode_i), .fmt_pins(ofmt_i),
    .fmt_q(fmt_q), .is_master(is_master), .is_slave(is_slave), .div_n(div_n),
    .left_lvl(left_lvl)
  );

  assign master_run = is_master && !pdn;
  assign slave_run  = is_slave && !pdn;

  aud_tx_mclkgen #(.SLOT_W(SLOT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(master_run), .div_n(div_n), .left_lvl(left_lvl),
    .tick(m_tick), .lrck_nxt(m_lrck), .bclk_o(bclk_o), .lrck_o(lrck_o)
  );

  aud_tx_slvsync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .run(slave_run), .bclk_in(bclk_i), .lrck_in(lrck_i),
    .tick(s_tick), .lrck_lvl(s_lrck)
  );

  always_comb begin
    tick     = is_master ? m_tick : (is_slave ? s_tick : 1'b0);
    lrck_lvl = is_master ? m_lrck : (is_slave ? s_lrck : 1'b0);
  end

  aud_tx_framer u_frm (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .tick(tick), .lrck_lvl(lrck_lvl),
    .fmt(fmt_q), .left_lvl(left_lvl), .smp_wr(smp_wr_i), .smp_l(smp_l_i),
    .smp_r(smp_r_i), .sdata_o(sdata_o)
  );

  assert_pdn_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> (!bclk_o && !lrck_o && !sdata_o));

  assert_lrck_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n || pdn)
    (master_run && !$stable(lrck_o)) |-> $fell(bclk_o));

  assert_data_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n || pdn)
    (master_run && !$stable(sdata_o)) |-> $fell(bclk_o));

  assert_follow_clocks_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_slave |-> (!bclk_o && !lrck_o));

  assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !is_slave) |-> (!bclk_o && !lrck_o && !sdata_o));
endmodule

// File: tb/aud_ser_tx_tb.sv
`timescale 1ns/1ps
module aud_ser_tx_tb;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdn = 1'b1;
  logic [2:0]  cmode_i = 3'b100;
  logic [1:0]  ofmt_i = 2'b10;
  logic        smp_wr_i = 1'b0;
  logic [19:0] smp_l_i = '0;
  logic [19:0] smp_r_i = '0;
  logic        bclk_i = 1'b1;
  logic        lrck_i = 1'b0;
  logic        bclk_o, lrck_o, sdata_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  aud_ser_tx u_dut (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .cmode_i(cmode_i), .ofmt_i(ofmt_i),
    .smp_wr_i(smp_wr_i), .smp_l_i(smp_l_i), .smp_r_i(smp_r_i), .bclk_i(bclk_i),
    .lrck_i(lrck_i), .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected bit in slot b of a half-frame of hl slots
  function automatic logic ref_bit(int fmt, logic [19:0] s, logic [19:0] sp, int b, int hl);
    int wl, first;
    if (fmt == 0)      wl = 16;
    else if (fmt == 1) wl = 20;
    else               wl = (hl == 16) ? 16 : 20;
    if (fmt < 2)       first = hl - wl;
    else if (fmt == 3) first = 1;
    else               first = 0;
    if (b >= first && b < first + wl) return s[19 - (b - first)];
    if (fmt == 3 && b == 0 && hl == wl) return sp[20 - wl];
    return 1'b0;
  endfunction

  // ---------------- per-cycle reference model ----------------
  int          m_mode = 4, m_fmt = 2;
  bit          chk_on = 0, chk_sd = 1;
  string       scn = "reset";
  logic [19:0] mh_l = '0, mh_r = '0, mf_l = '0, mf_r = '0;
  int          m_e = 0, m_ticks = 0;
  logic        x_bclk = 0, x_lrck = 0, x_sd = 0;

  function automatic int ratio(int md);
    case (md)
      0: return 4; 1: return 6; 2: return 8; 3: return 12; 7: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int n, slot, b, half;
    logic lft;
    if (pdn || !rst_n) begin
      m_e = 0; m_ticks = 0; x_bclk = 0; x_lrck = 0; x_sd = 0;
    end else begin
      n = ratio(m_mode);
      if (n != 0) begin
        m_e++;
        if (m_e % n == 0) begin
          m_ticks++;
          slot = (m_ticks - 1) % 64;
          if (slot == 0) begin mf_l = mh_l; mf_r = mh_r; end
          half = slot / 32;
          b    = slot % 32;
          lft  = (m_fmt == 3) ? 1'b0 : 1'b1;
          x_lrck = (half == 0) ? lft : ~lft;
          x_sd   = ref_bit(m_fmt, half ? mf_r : mf_l, '0, b, 32);
        end
        x_bclk = ((m_e % n) >= n / 2);
      end
    end
    if (!rst_n) begin mh_l = '0; mh_r = '0; end
    else if (smp_wr_i) begin mh_l = smp_l_i; mh_r = smp_r_i; end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check({"R2 bclk ", scn}, bclk_o, x_bclk);
      check({"R3 lrck ", scn}, lrck_o, x_lrck);
      if (chk_sd) check({"R4 R12 sdata ", scn}, sdata_o, x_sd);
    end
  end

  task automatic write_smp(input logic [19:0] l, input logic [19:0] r);
    @(negedge clk);
    smp_l_i = l; smp_r_i = r; smp_wr_i = 1'b1;
    @(negedge clk);
    smp_wr_i = 1'b0;
  endtask

  task automatic configure(input int md, input int fm);
    @(negedge clk);
    pdn = 1'b1; cmode_i = 3'(md); ofmt_i = 2'(fm); m_mode = md; m_fmt = fm;
    repeat (4) @(negedge clk);
    check("R1 pdn quiet bclk", bclk_o, 1'b0);
    check("R1 pdn quiet lrck", lrck_o, 1'b0);
    check("R1 pdn quiet sdata", sdata_o, 1'b0);
    pdn = 1'b0;
  endtask

  task automatic master_run(input int md, input int fm, input string tag, input bit pin_flip);
    int n;
    logic [19:0] v;
    scn = tag;
    configure(md, fm);
    n = ratio(md);
    v = 20'h5A3C7 ^ 20'(md * 4099 + fm * 777);
    for (int f = 0; f < 3; f++) begin
      // R12: writes in mid-frame must wait for the next left half
      repeat (n * 20) @(negedge clk);
      write_smp(v, ~v ^ 20'h0F0F1);
      v = {v[18:0], v[19] ^ v[16]};
      if (pin_flip && f == 0) begin
        scn = {tag, " R1 pins moved"};
        cmode_i = 3'b000; ofmt_i = 2'b11;
      end
      repeat (n * 44 - 2) @(negedge clk);
    end
  endtask

  task automatic slave_run(input int fm, input int hl, input string tag);
    logic lft;
    int hv;
    scn = tag;
    chk_sd = 0;
    lft = (fm == 3) ? 1'b0 : 1'b1;
    bclk_i = 1'b1; lrck_i = ~lft;
    configure(4, fm);
    for (int f = 0; f < 4; f++)
      for (int h = 0; h < 2; h++)
        for (int b = 0; b < hl; b++) begin
          @(negedge clk);
          bclk_i = 1'b0;
          hv = h;
          lrck_i = (hv == 0) ? lft : ~lft;
          repeat (3) @(negedge clk);
          if (f >= 2)
            check({"R10 R9 follow ", tag}, sdata_o,
                  ref_bit(fm, (h == 0) ? smp_l_i : smp_r_i,
                          (h == 0) ? smp_r_i : smp_l_i, b, hl));
          @(negedge clk);
          bclk_i = 1'b1;
          repeat (3) @(negedge clk);
        end
    chk_sd = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset bclk", bclk_o, 1'b0);
    check("R1 reset lrck", lrck_o, 1'b0);
    check("R1 reset sdata", sdata_o, 1'b0);
    chk_on = 1;
    write_smp(20'hA5C3F, 20'h3C96E);
    master_run(0, 0, "R5 div4 rj16", 0);
    master_run(1, 1, "R6 div6 rj20", 0);
    master_run(2, 2, "R7 div8 lj", 1);
    master_run(3, 3, "R8 div12 i2s", 0);
    master_run(7, 2, "R2 bypass lj", 0);
    scn = "R11 reserved";
    configure(5, 1);
    repeat (300) @(negedge clk);
    configure(6, 3);
    repeat (300) @(negedge clk);
    write_smp(20'hC3A59, 20'h6D2B4);
    slave_run(2, 32, "R7 lj 64fs");
    slave_run(2, 16, "R9 lj 32fs");
    slave_run(3, 16, "R8 i2s 32fs");
    slave_run(3, 24, "R9 i2s 48fs");
    slave_run(1, 32, "R6 rj20 64fs");
    chk_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule